// File: doc/BRIEF.md
# Dual-Bank Vector Register Operand Unit

This block is the operand fetch and result writeback stage of a small SIMD core. It stores two banks of vector registers, A and B, and six accumulators. Each vector is LANES lanes of LANE_W bits. Every cycle with `issue` high, the unit does the following:

- It resolves two operand slots. A slot reads an accumulator, a bank register, a peripheral or a replicated small immediate.
- It can unpack operand slot 0.
- It accepts up to two results, one from the add path and one from the multiply path.
- It checks the instruction against the operand rules.

Any rule breach raises `violation` with a code. A breached instruction has no effect on state, and its operands read as zero, so the unit never hands out wrong data quietly.

Accumulators and banks behave differently in time:

- **Accumulators:** they update on the clock edge that ends the issuing cycle, so the next instruction reads the new value.
- **Banks:** results are parked in a pending writeback stage and reach the array one edge later. A read of that register in the following cycle returns the old value and raises `hazard_flag`.

A finite-state machine tracks the pending stage with four states:

- `WB_IDLE`: nothing pending.
- `WB_A`: a bank A write is pending.
- `WB_B`: a bank B write is pending.
- `WB_AB`: one write is pending in each bank.

Each cycle the next state follows the accepted bank writes of the current instruction: none goes to `WB_IDLE`, A only to `WB_A`, B only to `WB_B`, and both to `WB_AB`. This holds from any state. A state with a pending bank commits that bank's parked result on the next edge.

A bank address of 2^BANK_AW or more is not storage. It reaches a shared peripheral port: the bank bit and the low address bits appear there, along with write data or returned read data.

Top module: `simd_opnd_unit`

## Requirements
- R1: After reset every accumulator reads zero, `hazard_flag`, `violation`, `viol_code`, `periph_rd_en` and `periph_wr_en` are low, and no bank write is pending.
- R2: A result written to bank register n < 32 (destination code 2 = bank A, 3 = bank B) returns the old value with `hazard_flag` high when read by the very next instruction, and the new value with `hazard_flag` low from the instruction after that.
- R3: A result written to accumulator k (destination code 1, k in 0..5) by either path is returned to the very next instruction (source code 0) with `hazard_flag` low; r0..r5 reset to zero.
- R4: Two operand slots reading the same bank (source code 1 = A, 2 = B) at different indices set `viol_code` bit 0; the same index in both is one legal read and both slots return it.
- R5: A small immediate (source code 3) is the 6-bit `imm_val` sign-extended into every lane; combining it with any bank B read sets `viol_code` bit 1.
- R6: With `unpack_en`, slot 0 lanes become quarter `unpack_sel` of each lane (bits sel*LANE_W/4 upward), zero-extended; it is legal only when slot 0 is a bank A register below 32 or accumulator 4, else `viol_code` bit 2.
- R7: Add and multiply destinations in the same bank set `viol_code` bit 3.
- R8: Both paths writing the same accumulator set `viol_code` bit 4; any accumulator index above 5 in a slot or destination sets bit 5.
- R9: A bank operand index of 32 or more raises `periph_rd_en` with `periph_rd_bank` (0 = A) and `periph_rd_addr` = index mod 32, and the slot returns `periph_rd_data`; two different peripheral reads in one instruction set bit 6.
- R10: A bank destination index of 32 or more drives `periph_wr_en`, bank, address and data in the issuing cycle and leaves the bank array untouched; two peripheral writes in one instruction set bit 6.
- R11: When `violation` is high, no accumulator, bank or peripheral write takes place, `periph_rd_en` is low and both operands are zero.
- R12: With `issue` low, nothing is written, both operands, `viol_code`, `hazard_flag` and the peripheral enables are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Instruction present this cycle |
| op0_src | input | 2 | Slot 0 source: 0 acc, 1 bank A, 2 bank B, 3 immediate |
| op0_idx | input | BANK_AW+1 | Slot 0 register index |
| op1_src | input | 2 | Slot 1 source, same codes |
| op1_idx | input | BANK_AW+1 | Slot 1 register index |
| imm_val | input | 6 | Signed small immediate |
| unpack_en | input | 1 | Unpack slot 0 |
| unpack_sel | input | 2 | Quarter of each lane to extract |
| add_dst | input | 2 | Add result target: 0 none, 1 acc, 2 bank A, 3 bank B |
| add_idx | input | BANK_AW+1 | Add result index |
| add_data | input | LANES*LANE_W | Add result vector |
| mul_dst | input | 2 | Multiply result target, same codes |
| mul_idx | input | BANK_AW+1 | Multiply result index |
| mul_data | input | LANES*LANE_W | Multiply result vector |
| periph_rd_en | output | 1 | Peripheral read strobe |
| periph_rd_bank | output | 1 | Bank space of the read (0 = A) |
| periph_rd_addr | output | BANK_AW | Peripheral read address |
| periph_rd_data | input | LANES*LANE_W | Peripheral read return |
| periph_wr_en | output | 1 | Peripheral write strobe |
| periph_wr_bank | output | 1 | Bank space of the write |
| periph_wr_addr | output | BANK_AW | Peripheral write address |
| periph_wr_data | output | LANES*LANE_W | Peripheral write vector |
| op0_data | output | LANES*LANE_W | Slot 0 operand |
| op1_data | output | LANES*LANE_W | Slot 1 operand |
| hazard_flag | output | 1 | A slot read a bank register still pending |
| violation | output | 1 | Instruction breaks an operand rule |
| viol_code | output | 7 | One bit per broken rule |

## Verification
A wrong writeback state shows up at the ports one instruction after the write. A stale `WB_*` state either misses or invents `hazard_flag`. A lost or doubled commit shows up one instruction later still, as a wrong bank value. A corrupted accumulator is visible on the very next read of it. A checker bug is visible in the same cycle: `viol_code` differs from its expected value, or a write that should have been suppressed alters a register, which the bench reads back two instructions later.

// File: rtl/simd_opnd_pkg.sv
package simd_opnd_pkg;

    typedef enum logic [1:0] {
        SRC_ACC   = 2'd0,
        SRC_BANKA = 2'd1,
        SRC_BANKB = 2'd2,
        SRC_IMM   = 2'd3
    } src_sel_e;

    typedef enum logic [1:0] {
        DST_NONE  = 2'd0,
        DST_ACC   = 2'd1,
        DST_BANKA = 2'd2,
        DST_BANKB = 2'd3
    } dst_sel_e;

    typedef enum logic [1:0] {
        WB_IDLE = 2'd0,
        WB_A    = 2'd1,
        WB_B    = 2'd2,
        WB_AB   = 2'd3
    } wb_state_e;

    localparam int NUM_ACC    = 6;
    localparam int ACC_IW     = 3;
    localparam int UNPACK_ACC = 4;
    localparam int IMM_W      = 6;
    localparam int VIOL_W     = 7;

    localparam int VB_DUAL_READ = 0;
    localparam int VB_IMM_B     = 1;
    localparam int VB_UNPACK    = 2;
    localparam int VB_DST_BANK  = 3;
    localparam int VB_DST_ACC   = 4;
    localparam int VB_ACC_RANGE = 5;
    localparam int VB_PERIPH    = 6;

endpackage

// File: rtl/simd_bank.sv
module simd_bank #(
    parameter int AW = 5,
    parameter int VW = 512
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [VW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [VW-1:0] rdata
);
    localparam int NREG = 1 << AW;

    logic [VW-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/simd_acc_file.sv
module simd_acc_file
    import simd_opnd_pkg::*;
#(
    parameter int VW = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_add,
    input  logic [ACC_IW-1:0] idx_add,
    input  logic [VW-1:0]     data_add,
    input  logic              we_mul,
    input  logic [ACC_IW-1:0] idx_mul,
    input  logic [VW-1:0]     data_mul,
    input  logic [ACC_IW-1:0] ridx0,
    output logic [VW-1:0]     rdata0,
    input  logic [ACC_IW-1:0] ridx1,
    output logic [VW-1:0]     rdata1
);
    logic [VW-1:0] acc_q [NUM_ACC];

    for (genvar k = 0; k < NUM_ACC; k++) begin : g_acc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q[k] <= '0;
            end else if (we_mul && (32'(idx_mul) == k)) begin
                acc_q[k] <= data_mul;
            end else if (we_add && (32'(idx_add) == k)) begin
                acc_q[k] <= data_add;
            end
        end
    end

    assign rdata0 = (32'(ridx0) < NUM_ACC) ? acc_q[ridx0] : '0;
    assign rdata1 = (32'(ridx1) < NUM_ACC) ? acc_q[ridx1] : '0;

endmodule

// File: rtl/simd_rule_chk.sv
module simd_rule_chk
    import simd_opnd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [1:0]        op0_src,
    input  logic [AW:0]       op0_idx,
    input  logic [1:0]        op1_src,
    input  logic [AW:0]       op1_idx,
    input  logic              unpack_en,
    input  logic [1:0]        add_dst,
    input  logic [AW:0]       add_idx,
    input  logic [1:0]        mul_dst,
    input  logic [AW:0]       mul_idx,
    output logic [VIOL_W-1:0] code
);
    src_sel_e s0, s1;
    dst_sel_e d0, d1;
    logic s0_bank, s1_bank, d0_bank, d1_bank;
    logic s0_per, s1_per, d0_per, d1_per;

    always_comb begin
        s0 = src_sel_e'(op0_src);
        s1 = src_sel_e'(op1_src);
        d0 = dst_sel_e'(add_dst);
        d1 = dst_sel_e'(mul_dst);
        s0_bank = (s0 == SRC_BANKA) || (s0 == SRC_BANKB);
        s1_bank = (s1 == SRC_BANKA) || (s1 == SRC_BANKB);
        d0_bank = (d0 == DST_BANKA) || (d0 == DST_BANKB);
        d1_bank = (d1 == DST_BANKA) || (d1 == DST_BANKB);
        s0_per  = s0_bank && op0_idx[AW];
        s1_per  = s1_bank && op1_idx[AW];
        d0_per  = d0_bank && add_idx[AW];
        d1_per  = d1_bank && mul_idx[AW];

        code = '0;
        code[VB_DUAL_READ] = s0_bank && (s0 == s1) && (op0_idx != op1_idx);
        code[VB_IMM_B]     = ((s0 == SRC_IMM) || (s1 == SRC_IMM)) &&
                             ((s0 == SRC_BANKB) || (s1 == SRC_BANKB));
        code[VB_UNPACK]    = unpack_en &&
                             !(((s0 == SRC_BANKA) && !op0_idx[AW]) ||
                               ((s0 == SRC_ACC) && (int'(op0_idx) == UNPACK_ACC)));
        code[VB_DST_BANK]  = d0_bank && (d0 == d1);
        code[VB_DST_ACC]   = (d0 == DST_ACC) && (d1 == DST_ACC) && (add_idx == mul_idx);
        code[VB_ACC_RANGE] = ((s0 == SRC_ACC) && (int'(op0_idx) >= NUM_ACC)) ||
                             ((s1 == SRC_ACC) && (int'(op1_idx) >= NUM_ACC)) ||
                             ((d0 == DST_ACC) && (int'(add_idx) >= NUM_ACC)) ||
                             ((d1 == DST_ACC) && (int'(mul_idx) >= NUM_ACC));
        code[VB_PERIPH]    = (s0_per && s1_per && ((s0 != s1) || (op0_idx != op1_idx))) ||
                             (d0_per && d1_per);
    end

endmodule

// File: rtl/simd_opnd_mux.sv
module simd_opnd_mux
    import simd_opnd_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int LANE_W = 32,
    parameter int AW     = 5
) (
    input  logic [1:0]              src,
    input  logic [AW:0]             idx,
    input  logic [LANES*LANE_W-1:0] acc_data,
    input  logic [LANES*LANE_W-1:0] bank_a_data,
    input  logic [LANES*LANE_W-1:0] bank_b_data,
    input  logic [LANES*LANE_W-1:0] periph_data,
    input  logic [IMM_W-1:0]        imm,
    input  logic                    unpack_en,
    input  logic [1:0]              unpack_sel,
    input  logic                    kill,
    output logic [LANES*LANE_W-1:0] data
);
    localparam int VW = LANES * LANE_W;
    localparam int QW = LANE_W / 4;

    logic [VW-1:0] raw;

    always_comb begin
        raw = '0;
        unique case (src_sel_e'(src))
            SRC_ACC:   raw = acc_data;
            SRC_BANKA: raw = idx[AW] ? periph_data : bank_a_data;
            SRC_BANKB: raw = idx[AW] ? periph_data : bank_b_data;
            SRC_IMM: begin
                for (int l = 0; l < LANES; l++) begin
                    raw[l*LANE_W +: LANE_W] = LANE_W'($signed(imm));
                end
            end
        endcase

        data = raw;
        if (unpack_en) begin
            for (int l = 0; l < LANES; l++) begin
                data[l*LANE_W +: LANE_W] =
                    LANE_W'(raw[l*LANE_W + int'(unpack_sel)*QW +: QW]);
            end
        end
        if (kill) begin
            data = '0;
        end
    end

endmodule

// File: rtl/simd_opnd_unit.sv
module simd_opnd_unit
    import simd_opnd_pkg::*;
#(
    parameter int LANES   = 16,
    parameter int LANE_W  = 32,
    parameter int BANK_AW = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      issue,
    input  logic [1:0]                op0_src,
    input  logic [BANK_AW:0]          op0_idx,
    input  logic [1:0]                op1_src,
    input  logic [BANK_AW:0]          op1_idx,
    input  logic [5:0]                imm_val,
    input  logic                      unpack_en,
    input  logic [1:0]                unpack_sel,
    input  logic [1:0]                add_dst,
    input  logic [BANK_AW:0]          add_idx,
    input  logic [LANES*LANE_W-1:0]   add_data,
    input  logic [1:0]                mul_dst,
    input  logic [BANK_AW:0]          mul_idx,
    input  logic [LANES*LANE_W-1:0]   mul_data,
    output logic                      periph_rd_en,
    output logic                      periph_rd_bank,
    output logic [BANK_AW-1:0]        periph_rd_addr,
    input  logic [LANES*LANE_W-1:0]   periph_rd_data,
    output logic                      periph_wr_en,
    output logic                      periph_wr_bank,
    output logic [BANK_AW-1:0]        periph_wr_addr,
    output logic [LANES*LANE_W-1:0]   periph_wr_data,
    output logic [LANES*LANE_W-1:0]   op0_data,
    output logic [LANES*LANE_W-1:0]   op1_data,
    output logic                      hazard_flag,
    output logic                      violation,
    output logic [6:0]                viol_code
);
    localparam int VW = LANES * LANE_W;
    localparam int NSLOT = 2;
    localparam int NBANK = 2;

    // ---------------- rule checker ----------------
    logic [VIOL_W-1:0] rule_code;
    logic              accept;

    simd_rule_chk #(.AW(BANK_AW)) u_rules (
        .op0_src   (op0_src),
        .op0_idx   (op0_idx),
        .op1_src   (op1_src),
        .op1_idx   (op1_idx),
        .unpack_en (unpack_en),
        .add_dst   (add_dst),
        .add_idx   (add_idx),
        .mul_dst   (mul_dst),
        .mul_idx   (mul_idx),
        .code      (rule_code)
    );

    assign viol_code = issue ? rule_code : '0;
    assign violation = |viol_code;
    assign accept    = issue && !violation;

    // ---------------- slot decode ----------------
    logic [1:0]         slot_src  [NSLOT];
    logic [BANK_AW:0]   slot_idx  [NSLOT];
    logic [VW-1:0]      slot_data [NSLOT];
    logic [VW-1:0]      slot_acc  [NSLOT];
    logic [NSLOT-1:0]   slot_bank;
    logic [NSLOT-1:0]   slot_in_b;
    logic [NSLOT-1:0]   slot_per;
    logic [NSLOT-1:0]   slot_haz;

    assign slot_src[0] = op0_src;
    assign slot_src[1] = op1_src;
    assign slot_idx[0] = op0_idx;
    assign slot_idx[1] = op1_idx;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot_dec
        assign slot_bank[s] = (src_sel_e'(slot_src[s]) == SRC_BANKA) ||
                              (src_sel_e'(slot_src[s]) == SRC_BANKB);
        assign slot_in_b[s] = (src_sel_e'(slot_src[s]) == SRC_BANKB);
        assign slot_per[s]  = slot_bank[s] && slot_idx[s][BANK_AW];
    end

    // ---------------- bank storage ----------------
    logic [NBANK-1:0]   cm_we;
    logic [BANK_AW-1:0] cm_addr [NBANK];
    logic [VW-1:0]      cm_data [NBANK];
    logic [BANK_AW-1:0] bk_raddr [NBANK];
    logic [VW-1:0]      bk_rdata [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bk_raddr[b] = (slot_bank[0] && (slot_in_b[0] == (b == 1)))
                             ? slot_idx[0][BANK_AW-1:0]
                             : slot_idx[1][BANK_AW-1:0];
        simd_bank #(.AW(BANK_AW), .VW(VW)) u_bank (
            .clk   (clk),
            .we    (cm_we[b]),
            .waddr (cm_addr[b]),
            .wdata (cm_data[b]),
            .raddr (bk_raddr[b]),
            .rdata (bk_rdata[b])
        );
    end

    // ---------------- accumulators ----------------
    logic add_acc_we, mul_acc_we;

    assign add_acc_we = accept && (dst_sel_e'(add_dst) == DST_ACC);
    assign mul_acc_we = accept && (dst_sel_e'(mul_dst) == DST_ACC);

    simd_acc_file #(.VW(VW)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_add   (add_acc_we),
        .idx_add  (add_idx[ACC_IW-1:0]),
        .data_add (add_data),
        .we_mul   (mul_acc_we),
        .idx_mul  (mul_idx[ACC_IW-1:0]),
        .data_mul (mul_data),
        .ridx0    (op0_idx[ACC_IW-1:0]),
        .rdata0   (slot_acc[0]),
        .ridx1    (op1_idx[ACC_IW-1:0]),
        .rdata1   (slot_acc[1])
    );

    // ---------------- operand muxes ----------------
    for (genvar s = 0; s < NSLOT; s++) begin : g_mux
        simd_opnd_mux #(.LANES(LANES), .LANE_W(LANE_W), .AW(BANK_AW)) u_mux (
            .src         (slot_src[s]),
            .idx         (slot_idx[s]),
            .acc_data    (slot_acc[s]),
            .bank_a_data (bk_rdata[0]),
            .bank_b_data (bk_rdata[1]),
            .periph_data (periph_rd_data),
            .imm         (imm_val),
            .unpack_en   ((s == 0) ? unpack_en : 1'b0),
            .unpack_sel  (unpack_sel),
            .kill        (!accept),
            .data        (slot_data[s])
        );
    end

    assign op0_data = slot_data[0];
    assign op1_data = slot_data[1];

    // ---------------- writeback decode ----------------
    logic add_bk, mul_bk, add_pw, mul_pw;
    logic wr_a, wr_b, add_to_a, add_to_b;

    always_comb begin
        add_bk   = accept && add_dst[1] && !add_idx[BANK_AW];
        mul_bk   = accept && mul_dst[1] && !mul_idx[BANK_AW];
        add_pw   = accept && add_dst[1] &&  add_idx[BANK_AW];
        mul_pw   = accept && mul_dst[1] &&  mul_idx[BANK_AW];
        add_to_a = add_bk && (dst_sel_e'(add_dst) == DST_BANKA);
        add_to_b = add_bk && (dst_sel_e'(add_dst) == DST_BANKB);
        wr_a     = add_to_a || (mul_bk && (dst_sel_e'(mul_dst) == DST_BANKA));
        wr_b     = add_to_b || (mul_bk && (dst_sel_e'(mul_dst) == DST_BANKB));
    end

    // ---------------- writeback FSM ----------------
    wb_state_e wb_state, wb_next;

    always_comb begin
        unique case ({wr_a, wr_b})
            2'b00: wb_next = WB_IDLE;
            2'b10: wb_next = WB_A;
            2'b01: wb_next = WB_B;
            2'b11: wb_next = WB_AB;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_state <= WB_IDLE;
        end else begin
            wb_state <= wb_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cm_addr[0] <= '0;
            cm_addr[1] <= '0;
        end else begin
            if (wr_a) cm_addr[0] <= add_to_a ? add_idx[BANK_AW-1:0] : mul_idx[BANK_AW-1:0];
            if (wr_b) cm_addr[1] <= add_to_b ? add_idx[BANK_AW-1:0] : mul_idx[BANK_AW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_a) cm_data[0] <= add_to_a ? add_data : mul_data;
        if (wr_b) cm_data[1] <= add_to_b ? add_data : mul_data;
    end

    always_comb begin
        unique case (wb_state)
            WB_IDLE: cm_we = 2'b00;
            WB_A:    cm_we = 2'b01;
            WB_B:    cm_we = 2'b10;
            WB_AB:   cm_we = 2'b11;
        endcase
    end

    // ---------------- hazard ----------------
    for (genvar s = 0; s < NSLOT; s++) begin : g_haz
        assign slot_haz[s] = slot_bank[s] && !slot_idx[s][BANK_AW] &&
                             cm_we[slot_in_b[s]] &&
                             (slot_idx[s][BANK_AW-1:0] == cm_addr[slot_in_b[s]]);
    end

    assign hazard_flag = issue && (|slot_haz);

    // ---------------- peripheral port ----------------
    always_comb begin
        periph_rd_en   = accept && (|slot_per);
        periph_rd_bank = slot_per[0] ? slot_in_b[0] : slot_in_b[1];
        periph_rd_addr = slot_per[0] ? slot_idx[0][BANK_AW-1:0] : slot_idx[1][BANK_AW-1:0];

        periph_wr_en   = add_pw || mul_pw;
        periph_wr_bank = add_pw ? add_dst[0] : mul_dst[0];
        periph_wr_addr = add_pw ? add_idx[BANK_AW-1:0] : mul_idx[BANK_AW-1:0];
        periph_wr_data = add_pw ? add_data : mul_data;
    end

endmodule

// File: rtl/simd_opnd_unit_chk.sv
module simd_opnd_unit_chk #(
    parameter int LANES   = 16,
    parameter int LANE_W  = 32,
    parameter int BANK_AW = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    issue,
    input logic [1:0]              op0_src,
    input logic [BANK_AW:0]        op0_idx,
    input logic [1:0]              op1_src,
    input logic [BANK_AW:0]        op1_idx,
    input logic                    unpack_en,
    input logic [1:0]              add_dst,
    input logic [BANK_AW:0]        add_idx,
    input logic [LANES*LANE_W-1:0] add_data,
    input logic [1:0]              mul_dst,
    input logic                    periph_wr_en,
    input logic                    periph_rd_en,
    input logic [LANES*LANE_W-1:0] op0_data,
    input logic [LANES*LANE_W-1:0] op1_data,
    input logic                    hazard_flag,
    input logic                    violation
);
    AST_VIOL_NO_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> (!periph_wr_en && !periph_rd_en)); // R11

    AST_VIOL_ZERO_OPS: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> (op0_data == '0 && op1_data == '0)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |-> (!violation && !hazard_flag && !periph_wr_en && !periph_rd_en)); // R12

    AST_HAZ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        hazard_flag |-> ($past(issue) && !$past(violation))); // R2

    AST_IMM_WITH_B: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (op0_src == 2'd3 || op1_src == 2'd3) &&
         (op0_src == 2'd2 || op1_src == 2'd2)) |-> violation); // R5

    AST_DUAL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op0_src == op1_src && (op0_src == 2'd1 || op0_src == 2'd2) &&
         op0_idx != op1_idx) |-> violation); // R4

    AST_ACC_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !violation && add_dst == 2'd1 && mul_dst != 2'd1) |=>
        (!(issue && !violation && !unpack_en && op0_src == 2'd0 &&
           op0_idx == $past(add_idx)) || op0_data == $past(add_data))); // R3

endmodule

bind simd_opnd_unit simd_opnd_unit_chk #(
    .LANES(LANES), .LANE_W(LANE_W), .BANK_AW(BANK_AW)
) u_chk (.*);

// File: tb/simd_opnd_unit_bench.sv
`timescale 1ns/1ps
module simd_opnd_unit_bench;
    localparam int LANES = 4;
    localparam int LW    = 16;
    localparam int AW    = 5;
    localparam int VW    = LANES * LW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue;
    logic [1:0] op0_src, op1_src, add_dst, mul_dst, unpack_sel;
    logic [AW:0] op0_idx, op1_idx, add_idx, mul_idx;
    logic [5:0] imm_val;
    logic unpack_en;
    logic [VW-1:0] add_data, mul_data, periph_rd_data, periph_wr_data, op0_data, op1_data;
    logic periph_rd_en, periph_rd_bank, periph_wr_en, periph_wr_bank;
    logic [AW-1:0] periph_rd_addr, periph_wr_addr;
    logic hazard_flag, violation;
    logic [6:0] viol_code;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    simd_opnd_unit #(.LANES(LANES), .LANE_W(LW), .BANK_AW(AW)) u_simd_opnd_unit (.*);

    task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] pat(int bank, int idx, int salt);
        logic [VW-1:0] v;
        for (int l = 0; l < LANES; l++) v[l*LW +: LW] = 16'(bank*4099 + idx*263 + l*31 + salt*7919 + 1);
        return v;
    endfunction

    task automatic quiet();
        issue = 0; op0_src = 0; op0_idx = 0; op1_src = 0; op1_idx = 0;
        imm_val = 0; unpack_en = 0; unpack_sel = 0;
        add_dst = 0; add_idx = 0; add_data = '0;
        mul_dst = 0; mul_idx = 0; mul_data = '0;
    endtask

    // begin a new cycle: after the edge, reset the fields
    task automatic next_cyc();
        @(posedge clk); #1; quiet();
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic rd(input logic [1:0] s0, input int i0, input logic [1:0] s1, input int i1);
        issue = 1; op0_src = s0; op0_idx = 6'(i0); op1_src = s1; op1_idx = 6'(i1);
    endtask

    initial begin
        quiet();
        periph_rd_data = 64'hA5A5_3C3C_0F0F_9696;
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        settle();
        // R1: idle outputs after reset
        chk("R1 violation", VW'(violation), '0);
        chk("R1 hazard", VW'(hazard_flag), '0);
        chk("R1 periph enables", VW'({periph_rd_en, periph_wr_en}), '0);
        for (int k = 0; k < 6; k++) begin
            next_cyc(); rd(2'd0, k, 2'd0, k); settle();
            chk("R1 acc reset", op0_data, '0);
            chk("R1 no hazard", VW'(hazard_flag), '0);
        end

        // R2: fill both banks
        for (int i = 0; i < 32; i++) begin
            next_cyc(); issue = 1; op0_src = 2'd3;
            add_dst = 2'd2; add_idx = 6'(i); add_data = pat(0, i, 0);
            mul_dst = 2'd3; mul_idx = 6'(i); mul_data = pat(1, i, 0);
        end
        for (int i = 0; i < 32; i++) begin
            next_cyc(); issue = 1; op0_src = 2'd3;
            if (i % 2 == 0) begin
                add_dst = 2'd2; add_idx = 6'(i); add_data = pat(0, i, 1);
                mul_dst = 2'd3; mul_idx = 6'(i); mul_data = pat(1, i, 1);
            end else begin
                mul_dst = 2'd2; mul_idx = 6'(i); mul_data = pat(0, i, 1);
                add_dst = 2'd3; add_idx = 6'(i); add_data = pat(1, i, 1);
            end
            next_cyc(); rd(2'd1, i, 2'd2, i); settle();
            chk("R2 stale A", op0_data, pat(0, i, 0));
            chk("R2 stale B", op1_data, pat(1, i, 0));
            chk("R2 hazard set", VW'(hazard_flag), 1);
            next_cyc(); rd(2'd1, i, 2'd2, i); settle();
            chk("R2 new A", op0_data, pat(0, i, 1));
            chk("R2 new B", op1_data, pat(1, i, 1));
            chk("R2 hazard clear", VW'(hazard_flag), 0);
        end

        // R3: accumulator forwarding, both paths
        for (int k = 0; k < 6; k++) begin
            next_cyc(); issue = 1; op0_src = 2'd3;
            add_dst = 2'd1; add_idx = 6'(k); add_data = pat(2, k, 0);
            next_cyc(); rd(2'd0, k, 2'd0, k); settle();
            chk("R3 add fwd", op0_data, pat(2, k, 0));
            chk("R3 no hazard", VW'(hazard_flag), 0);
            next_cyc(); issue = 1; op0_src = 2'd3;
            mul_dst = 2'd1; mul_idx = 6'(k); mul_data = pat(3, k, 0);
            next_cyc(); rd(2'd0, 0, 2'd0, k); settle();
            chk("R3 mul fwd", op1_data, pat(3, k, 0));
        end

        // R4: dual read sweep
        for (int b = 1; b <= 2; b++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    next_cyc(); rd(2'(b), i, 2'(b), j); settle();
                    chk("R4 code", VW'(viol_code), (i != j) ? 1 : 0);
                    chk("R4 data", op1_data, (i != j) ? '0 : pat(b - 1, i, 1));
                end
            end
        end

        // R5: immediate replication and combination with bank B
        for (int v = 0; v < 64; v++) begin
            next_cyc(); rd(2'd3, 0, 2'd0, 0); imm_val = 6'(v); settle();
            chk("R5 imm lanes", op0_data,
                {LANES{(v >= 32) ? 16'(v - 64) : 16'(v)}});
        end
        for (int s0 = 0; s0 < 4; s0++) begin
            for (int s1 = 0; s1 < 4; s1++) begin
                next_cyc();
                rd(2'(s0), (s0 == 0) ? 1 : 2, 2'(s1), (s1 == 0) ? 1 : 2); settle();
                chk("R5 code", VW'(viol_code),
                    ((s0 == 3 || s1 == 3) && (s0 == 2 || s1 == 2)) ? 2 : 0);
            end
        end

        // R6: unpack
        for (int q = 0; q < 4; q++) begin
            logic [VW-1:0] ea, e4;
            for (int l = 0; l < LANES; l++) begin
                ea[l*LW +: LW] = 16'(pat(0, 5, 1)[l*LW + q*4 +: 4]);
                e4[l*LW +: LW] = 16'(pat(3, 4, 0)[l*LW + q*4 +: 4]);
            end
            next_cyc(); rd(2'd1, 5, 2'd0, 0); unpack_en = 1; unpack_sel = 2'(q); settle();
            chk("R6 unpack A", op0_data, ea);
            next_cyc(); rd(2'd0, 4, 2'd0, 0); unpack_en = 1; unpack_sel = 2'(q); settle();
            chk("R6 unpack r4", op0_data, e4);
        end
        next_cyc(); rd(2'd0, 0, 2'd0, 1); unpack_en = 1; settle();
        chk("R6 bad acc", VW'(viol_code), 4);
        next_cyc(); rd(2'd2, 5, 2'd0, 1); unpack_en = 1; settle();
        chk("R6 bad bankB", VW'(viol_code), 4);
        next_cyc(); rd(2'd3, 0, 2'd0, 1); unpack_en = 1; settle();
        chk("R6 bad imm", VW'(viol_code), 4);
        next_cyc(); rd(2'd1, 40, 2'd0, 1); unpack_en = 1; settle();
        chk("R6 bad periph", VW'(viol_code), 4);

        // R9: peripheral reads
        next_cyc(); rd(2'd1, 40, 2'd0, 0); settle();
        chk("R9 rd port", VW'({periph_rd_en, periph_rd_bank, periph_rd_addr}), VW'({1'b1, 1'b0, 5'd8}));
        chk("R9 rd data", op0_data, periph_rd_data);
        next_cyc(); rd(2'd0, 0, 2'd2, 63); settle();
        chk("R9 rd port B", VW'({periph_rd_en, periph_rd_bank, periph_rd_addr}), VW'({1'b1, 1'b1, 5'd31}));
        chk("R9 rd data B", op1_data, periph_rd_data);
        next_cyc(); rd(2'd1, 35, 2'd1, 35); settle();
        chk("R9 shared read", VW'(viol_code), 0);
        chk("R9 shared data", op1_data, periph_rd_data);
        next_cyc(); rd(2'd1, 35, 2'd2, 35); settle();
        chk("R9 two periph reads", VW'(viol_code), 64);
        chk("R11 no periph read", VW'(periph_rd_en), 0);

        // R10: peripheral writes
        next_cyc(); issue = 1; op0_src = 2'd3;
        add_dst = 2'd3; add_idx = 6'd33; add_data = pat(7, 1, 0); settle();
        chk("R10 wr port", VW'({periph_wr_en, periph_wr_bank, periph_wr_addr}), VW'({1'b1, 1'b1, 5'd1}));
        chk("R10 wr data", periph_wr_data, pat(7, 1, 0));
        next_cyc(); issue = 1; op0_src = 2'd3;
        mul_dst = 2'd2; mul_idx = 6'd50; mul_data = pat(7, 2, 0); settle();
        chk("R10 wr port mul", VW'({periph_wr_en, periph_wr_bank, periph_wr_addr}), VW'({1'b1, 1'b0, 5'd18}));
        chk("R10 wr data mul", periph_wr_data, pat(7, 2, 0));
        next_cyc(); issue = 1; op0_src = 2'd3;
        add_dst = 2'd3; add_idx = 6'd33; mul_dst = 2'd2; mul_idx = 6'd34; settle();
        chk("R10 two periph writes", VW'(viol_code), 64);
        chk("R11 no periph write", VW'(periph_wr_en), 0);
        next_cyc(); next_cyc(); rd(2'd1, 18, 2'd2, 1); settle();
        chk("R10 bank A untouched", op0_data, pat(0, 18, 1));
        chk("R10 bank B untouched", op1_data, pat(1, 1, 1));

        // R7: destination sweep
        for (int d0 = 0; d0 < 4; d0++) begin
            for (int d1 = 0; d1 < 4; d1++) begin
                next_cyc(); issue = 1; op0_src = 2'd3;
                add_dst = 2'(d0); add_idx = (d0 == 1) ? 6'd1 : 6'd9; add_data = pat(4, d0, d1);
                mul_dst = 2'(d1); mul_idx = (d1 == 1) ? 6'd2 : 6'd9; mul_data = pat(5, d0, d1);
                settle();
                chk("R7 code", VW'(viol_code), (d0 == d1 && d0 >= 2) ? 8 : 0);
            end
        end

        // R8 and R11: accumulator conflicts suppress writes
        next_cyc(); issue = 1; op0_src = 2'd3;
        add_dst = 2'd1; add_idx = 6'd3; add_data = '1;
        mul_dst = 2'd1; mul_idx = 6'd3; mul_data = '1; settle();
        chk("R8 same acc", VW'(viol_code), 16);
        next_cyc(); rd(2'd0, 3, 2'd0, 6); settle();
        chk("R8 acc range", VW'(viol_code), 32);
        chk("R11 zero op", op0_data, '0);
        next_cyc(); rd(2'd0, 3, 2'd0, 3); settle();
        chk("R11 acc kept", op0_data, pat(3, 3, 0));
        next_cyc(); issue = 1; op0_src = 2'd3;
        add_dst = 2'd1; add_idx = 6'd7; add_data = '1; settle();
        chk("R8 acc dst range", VW'(viol_code), 32);
        next_cyc(); issue = 1; op0_src = 2'd3;
        add_dst = 2'd2; add_idx = 6'd9; add_data = '1;
        mul_dst = 2'd2; mul_idx = 6'd20; mul_data = '1; settle();
        chk("R7 same bank", VW'(viol_code), 8);
        next_cyc(); next_cyc(); rd(2'd1, 20, 2'd0, 0); settle();
        chk("R11 bank kept", op0_data, pat(0, 20, 1));

        // R12: no issue
        next_cyc(); issue = 0; op0_src = 2'd1; op0_idx = 6'd7; op1_src = 2'd1; op1_idx = 6'd8;
        add_dst = 2'd2; add_idx = 6'd7; add_data = '1;
        mul_dst = 2'd1; mul_idx = 6'd0; mul_data = '1; settle();
        chk("R12 code", VW'(viol_code), 0);
        chk("R12 ops", op0_data | op1_data, '0);
        chk("R12 flags", VW'({hazard_flag, periph_rd_en, periph_wr_en}), 0);
        next_cyc(); next_cyc(); rd(2'd1, 7, 2'd0, 0); settle();
        chk("R12 bank kept", op0_data, pat(0, 7, 1));
        chk("R12 acc kept", op1_data, pat(3, 0, 0));

        next_cyc();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule